// File: doc/BRIEF.md
# UART Receiver with Error Status

This block is the receive half of an asynchronous serial port. A 16x-oversampled receiver watches a single serial line and builds 8-bit or 9-bit characters, sent least significant bit first. Each completed character goes into a one-entry holding buffer, which is offered downstream on a valid/ready stream. The baud rate is supplied from outside as a one-cycle tick enable at sixteen times the bit rate.

Alongside reception, the block keeps an error status register. The register holds three sticky flags (framing error, start of break, overrun) and one enable bit. The enable bit lets those flags contribute to the receive interrupt. Software reads the register through a plain register port. A write sets the enable bit directly and clears any flag whose position is written as 1.

Stream rules: `rx_valid` is high while the buffer holds an unread character, and `rx_data` stays steady for as long as it is. A transfer happens on a rising clock edge where `rx_valid` and `rx_ready` are both high. `rx_valid` drops after that edge unless a new character completes on the same edge. Holding `rx_ready` low never stalls the receiver. A character that completes while the buffer is full and not being taken is dropped, and the overrun flag records the loss.

Top module: `uart_rx_status`

## Requirements
- R1: After reset, `reg_rdata` reads 0x00, `rx_valid` is 0 and `irq` is 0.
- R2: A low level on the line starts a character only if the line is still low at the 8th tick after the tick on which the low was first seen. Otherwise the receiver returns to idle and nothing is stored.
- R3: Data bits are sampled every 16 ticks after the start-bit sample, least significant bit first. There are 8 bits when `frame9`=0 (`rx_data[8]` then reads 0) and 9 bits when `frame9`=1. The character appears on `rx_data` with `rx_valid`=1. `rx_valid` falls on the clock after a cycle with `rx_valid` and `rx_ready` both high.
- R4: Bit 3 of the status (framing error) sets when the stop bit, sampled 16 ticks after the last data bit, is low.
- R5: Bit 2 of the status (break) sets when every data bit and the stop bit are low. After a low stop bit, the receiver ignores the line until it has returned high.
- R6: Bit 1 of the status (overrun) sets when a character completes while `rx_valid` is high and not being taken. The buffered character is kept and the new one is dropped.
- R7: Bits 3:1 stay set until cleared. A write clears each of those bits that is written as 1. Bits 7:4 always read 0.
- R8: Bit 0 of the status (status interrupt enable) takes the value of `reg_wdata[0]` on a write and changes on nothing else.
- R9: `irq` is high exactly when `rx_valid` is high, or when bit 0 is set and any of bits 3:1 is set.
- R10: When a flag is set by a received character and cleared by a write in the same cycle, the flag ends up set.
- R11: The receiver advances only on cycles where `tick` is high. A character sent at any tick rate is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Enable pulse at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high |
| frame9 | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| rx_valid | output | 1 | Holding buffer holds an unread character |
| rx_ready | input | 1 | Downstream accepts the character |
| rx_data | output | 9 | Received character |
| reg_wr | input | 1 | Status register write strobe |
| reg_wdata | input | 8 | Write data: bit 0 enable value, bits 3:1 clear mask |
| reg_rdata | output | 8 | Status register read value |
| irq | output | 1 | Receive interrupt |

## Verification
The bench builds the block with its defaults: 16x oversampling, a 9-bit maximum character and a two-stage line synchronizer. With `tick` held high on every clock, each sample point falls on a known clock edge. The reference model can then follow the design cycle by cycle. This makes it possible to place a clearing write on exactly the edge where a flag sets, and to check the overrun/take ordering on known edges. A further run uses a tick on every fourth clock to show that the sampling counts only ticks.

// File: rtl/uart_rxs_pkg.sv
package uart_rxs_pkg;
  typedef enum logic [2:0] {
    RS_IDLE,
    RS_START,
    RS_DATA,
    RS_STOP,
    RS_HOLD
  } rx_state_t;

  localparam int STAT_W = 8;
  localparam int BIT_EN = 0;
  localparam int BIT_OE = 1;
  localparam int BIT_BR = 2;
  localparam int BIT_FE = 3;
endpackage

// File: rtl/uart_rxs_sync.sv
module uart_rxs_sync #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] s;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) s[0] <= INIT;
          else        s[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) s[i] <= INIT;
          else        s[i] <= s[i-1];
      end
    end
  endgenerate

  assign q = s[STAGES-1];
endmodule

// File: rtl/uart_rxs_frame.sv
module uart_rxs_frame
  import uart_rxs_pkg::*;
#(
  parameter int OVS       = 16,
  parameter int BASE_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 rx,
  input  logic                 frame9,
  output logic                 done,
  output logic [BASE_BITS:0]   data,
  output logic                 stop_bit,
  output logic                 all_zero
);
  localparam int DW    = BASE_BITS + 1;
  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DW);
  localparam int MID   = OVS / 2;
  localparam logic [CNT_W-1:0] MID_C  = CNT_W'(MID - 1);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(OVS - 1);

  rx_state_t        st;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic [DW-1:0]    shreg;
  logic             zero;
  logic [IDX_W-1:0] last_idx;

  assign last_idx = frame9 ? IDX_W'(DW - 1) : IDX_W'(DW - 2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= RS_IDLE;
      cnt   <= '0;
      idx   <= '0;
      shreg <= '0;
      zero  <= 1'b1;
    end else if (st == RS_HOLD) begin
      if (rx) st <= RS_IDLE;
    end else if (tick) begin
      case (st)
        RS_IDLE: begin
          if (!rx) begin
            st  <= RS_START;
            cnt <= '0;
          end
        end
        RS_START: begin
          if (cnt == MID_C) begin
            if (rx) st <= RS_IDLE;
            else begin
              st    <= RS_DATA;
              cnt   <= '0;
              idx   <= '0;
              shreg <= '0;
              zero  <= 1'b1;
            end
          end else cnt <= cnt + 1'b1;
        end
        RS_DATA: begin
          if (cnt == LAST_C) begin
            cnt        <= '0;
            shreg[idx] <= rx;
            zero       <= zero & ~rx;
            if (idx == last_idx) st <= RS_STOP;
            else                 idx <= idx + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        RS_STOP: begin
          if (cnt == LAST_C) begin
            cnt <= '0;
            st  <= rx ? RS_IDLE : RS_HOLD;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= RS_IDLE;
      endcase
    end
  end

  assign done     = (st == RS_STOP) && tick && (cnt == LAST_C);
  assign data     = shreg;
  assign stop_bit = rx;
  assign all_zero = zero;

  // R11: without a tick the sampling state does not move (hold state excepted)
  assert_tick_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && st != RS_HOLD) |=> ($stable(st) && $stable(cnt)));

  // R5: after a low stop bit the receiver stays parked while the line is low
  assert_hold_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !rx) |=> (st == RS_HOLD));
endmodule

// File: rtl/uart_rxs_status.sv
module uart_rxs_status
  import uart_rxs_pkg::*;
#(
  parameter int DW = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [DW-1:0]     frm_data,
  input  logic              stop_bit,
  input  logic              all_zero,
  input  logic              take,
  input  logic              wr,
  input  logic [STAT_W-1:0] wdata,
  output logic              valid,
  output logic [DW-1:0]     dout,
  output logic [STAT_W-1:0] stat,
  output logic              irq
);
  logic en, oe, br, fe;
  logic blocked, set_fe, set_br, set_oe;

  assign blocked = valid & ~take;
  assign set_fe  = done & ~stop_bit;
  assign set_br  = done & ~stop_bit & all_zero;
  assign set_oe  = done & blocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en    <= 1'b0;
      oe    <= 1'b0;
      br    <= 1'b0;
      fe    <= 1'b0;
      valid <= 1'b0;
      dout  <= '0;
    end else begin
      if (wr) en <= wdata[BIT_EN];
      fe <= (fe & ~(wr & wdata[BIT_FE])) | set_fe;
      br <= (br & ~(wr & wdata[BIT_BR])) | set_br;
      oe <= (oe & ~(wr & wdata[BIT_OE])) | set_oe;
      if (done && !blocked) begin
        valid <= 1'b1;
        dout  <= frm_data;
      end else if (take) begin
        valid <= 1'b0;
      end
    end
  end

  assign stat = {{(STAT_W-4){1'b0}}, fe, br, oe, en};
  assign irq  = valid | (en & (oe | br | fe));

  assert_en_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(en));

  assert_fe_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fe && !(wr && wdata[BIT_FE])) |=> fe);

  assert_oe_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && valid && !take) |=> (oe && valid && $stable(dout)));

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !stop_bit) |=> fe);

  assert_brk_fe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(br) |-> fe);

  assert_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && take && !done) |=> !valid);
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rxs_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int BASE_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               rxd,
  input  logic               frame9,
  output logic               rx_valid,
  input  logic               rx_ready,
  output logic [BASE_BITS:0] rx_data,
  input  logic               reg_wr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  output logic               irq
);
  localparam int DW = BASE_BITS + 1;

  logic          rx_s;
  logic          done, stop_bit, all_zero;
  logic [DW-1:0] frm_data;

  uart_rxs_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rxd), .q(rx_s)
  );

  uart_rxs_frame #(.OVS(OVS), .BASE_BITS(BASE_BITS)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx(rx_s), .frame9(frame9),
    .done(done), .data(frm_data), .stop_bit(stop_bit), .all_zero(all_zero)
  );

  uart_rxs_status #(.DW(DW)) u_status (
    .clk(clk), .rst_n(rst_n), .done(done), .frm_data(frm_data),
    .stop_bit(stop_bit), .all_zero(all_zero), .take(rx_ready),
    .wr(reg_wr), .wdata(reg_wdata), .valid(rx_valid), .dout(rx_data),
    .stat(reg_rdata), .irq(irq)
  );
endmodule

// File: tb/sim_uart_rx_status.sv
module sim_uart_rx_status;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       rxd = 1'b1;
  logic       frame9 = 1'b0;
  logic       rx_ready = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic       rx_valid, irq;
  logic [8:0] rx_data;
  logic [7:0] reg_rdata;

  int errors = 0;
  int checks = 0;
  int tick_div = 1;
  bit model_on = 0;

  // reference model state
  bit       m_valid, m_en, m_oe, m_br, m_fe;
  bit [8:0] m_data;

  uart_rx_status u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .frame9(frame9),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit [7:0] m_stat();
    return {4'b0, m_fe, m_br, m_oe, m_en};
  endfunction

  function automatic bit m_irq();
    return m_valid | (m_en & (m_oe | m_br | m_fe));
  endfunction

  task automatic m_write(input bit [7:0] v);
    m_en = v[0];
    if (v[1]) m_oe = 0;
    if (v[2]) m_br = 0;
    if (v[3]) m_fe = 0;
  endtask

  task automatic m_frame(input bit [8:0] d, input bit n9, input bit stopv);
    bit [8:0] dd;
    dd = n9 ? d : {1'b0, d[7:0]};
    if (!stopv) m_fe = 1;
    if (!stopv && dd == 9'd0) m_br = 1;
    if (m_valid) m_oe = 1;
    else begin
      m_valid = 1;
      m_data  = dd;
    end
  endtask

  // tick generator
  initial begin
    int tc = 0;
    forever begin
      @(negedge clk);
      tc = (tc + 1 >= tick_div) ? 0 : tc + 1;
      tick = (tc == 0);
    end
  end

  // per-clock comparison against the model
  initial begin
    forever begin
      @(negedge clk);
      if (model_on) begin
        chk(rx_valid == m_valid, "R3 rx_valid", rx_valid, m_valid);
        if (m_valid) chk(rx_data == m_data, "R3 rx_data", rx_data, m_data);
        chk(reg_rdata == m_stat(), "R7 status", reg_rdata, m_stat());
        chk(irq == m_irq(), "R9 irq", irq, m_irq());
      end
    end
  end

  task automatic do_wr(input bit [7:0] v);
    @(negedge clk);
    reg_wr = 1; reg_wdata = v;
    @(posedge clk);
    m_write(v);
    @(negedge clk);
    reg_wr = 0; reg_wdata = 8'h00;
  endtask

  task automatic take(input string tag, input bit [8:0] exp);
    @(negedge clk);
    chk(rx_valid == 1'b1, tag, rx_valid, 1);
    chk(rx_data == exp, tag, rx_data, exp);
    rx_ready = 1;
    @(posedge clk);
    m_valid = 0;
    @(negedge clk);
    rx_ready = 0;
    #1 chk(rx_valid == 1'b0, {tag, " drop"}, rx_valid, 0);
  endtask

  // cycle-exact frame with tick on every clock
  task automatic send(input bit [8:0] d, input bit n9, input bit stopv,
                      input bit collide, input bit [7:0] cv);
    int n, s, total, ix;
    bit v;
    n = n9 ? 9 : 8;
    s = 10 + 16 * (n + 1);
    total = 16 * (n + 2);
    @(negedge clk);
    frame9 = n9;
    rxd = 0;
    for (int c = 0; c < total; c++) begin
      @(posedge clk);
      if (collide && c == s) m_write(cv);
      if (c == s) m_frame(d, n9, stopv);
      @(negedge clk);
      ix = (c + 1) / 16;
      if (ix == 0) v = 0;
      else if (ix <= n) v = d[ix-1];
      else if (ix == n + 1) v = stopv;
      else v = 1;
      rxd = v;
      if (collide) begin
        reg_wr = (c + 1 == s);
        reg_wdata = cv;
      end
    end
    rxd = 1;
    reg_wr = 0;
    repeat (8) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 chk(reg_rdata == 8'h00, "R1 status reset", reg_rdata, 0);
    chk(rx_valid == 1'b0, "R1 valid reset", rx_valid, 0);
    chk(irq == 1'b0, "R1 irq reset", irq, 0);
    model_on = 1;
    @(negedge clk) rst_n = 1;
    repeat (4) @(negedge clk);

    // R3: 8-bit character then 9-bit character
    send(9'h1A5, 0, 1, 0, 0);
    take("R3 8-bit data", 9'h0A5);
    send(9'h1C3, 1, 1, 0, 0);
    take("R3 9-bit data", 9'h1C3);

    // R8: enable bit written
    do_wr(8'h01);
    #1 chk(reg_rdata[0] == 1'b1, "R8 enable set", reg_rdata, 1);

    // R4: framing error
    send(9'h05A, 0, 0, 0, 0);
    #1 chk(reg_rdata[3] == 1'b1, "R4 framing flag", reg_rdata, 8'h09);
    take("R4 data kept", 9'h05A);
    #1 chk(irq == 1'b1, "R9 irq from flag", irq, 1);
    do_wr(8'h09);
    #1 chk(reg_rdata == 8'h01, "R7 clear framing", reg_rdata, 1);

    // R5: break in both frame sizes
    send(9'h000, 0, 0, 0, 0);
    #1 chk(reg_rdata == 8'h0D, "R5 break 8-bit", reg_rdata, 8'h0D);
    take("R5 break data", 9'h000);
    do_wr(8'h0D);
    send(9'h000, 1, 0, 0, 0);
    #1 chk(reg_rdata == 8'h0D, "R5 break 9-bit", reg_rdata, 8'h0D);
    take("R5 break data 9", 9'h000);
    do_wr(8'h0F);

    // R6: overrun keeps first character
    send(9'h011, 0, 1, 0, 0);
    send(9'h022, 0, 1, 0, 0);
    #1 chk(reg_rdata[1] == 1'b1, "R6 overrun flag", reg_rdata, 8'h03);
    take("R6 kept data", 9'h011);

    // R7/R9: flags sticky, enable off leaves irq to valid only
    repeat (50) @(negedge clk);
    #1 chk(reg_rdata[1] == 1'b1, "R7 overrun sticky", reg_rdata, 8'h03);
    do_wr(8'h00);
    #1 chk(irq == 1'b0, "R9 irq masked", irq, 0);
    chk(reg_rdata == 8'h02, "R8 enable cleared flag kept", reg_rdata, 8'h02);
    do_wr(8'hF2);
    #1 chk(reg_rdata == 8'h00, "R7 upper bits zero", reg_rdata, 0);

    // R10: clear and set of framing flag on the same edge
    send(9'h03C, 0, 0, 1, 8'h08);
    #1 chk(reg_rdata[3] == 1'b1, "R10 set wins", reg_rdata, 8'h08);
    take("R10 data", 9'h03C);
    do_wr(8'h0E);

    // R2: short low pulse rejected
    @(negedge clk) rxd = 0;
    repeat (4) @(negedge clk);
    rxd = 1;
    repeat (40) @(negedge clk);
    #1 chk(rx_valid == 1'b0, "R2 glitch ignored", rx_valid, 0);
    chk(reg_rdata == 8'h00, "R2 no flags", reg_rdata, 0);

    // R11: tick every fourth clock, 64 clocks per bit
    model_on = 0;
    tick_div = 4;
    frame9 = 0;
    repeat (8) @(negedge clk);
    for (int b = 0; b < 10; b++) begin
      if (b == 0) rxd = 0;
      else if (b <= 8) rxd = 9'h0B6 >> (b - 1);
      else rxd = 1;
      repeat (64) @(negedge clk);
    end
    repeat (40) @(negedge clk);
    m_frame(9'h0B6, 0, 1);
    tick_div = 1;
    #1 chk(rx_valid == 1'b1, "R11 divided tick valid", rx_valid, 1);
    chk(rx_data == 9'h0B6, "R11 divided tick data", rx_data, 9'h0B6);
    model_on = 1;
    take("R11 take", 9'h0B6);

    repeat (5) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule